// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block is an I2C target that sits in front of a 256-entry, 8-bit memory and behaves like a small serial EEPROM. It samples the SCL and SDA lines with the system clock and finds START, repeated START and STOP. It accepts a 7-bit device address followed by a read/write bit. It pulls SDA low through an open-drain output enable, both to acknowledge and to send zero bits.

One internal address counter serves every access. Its value carries over from one bus transaction to the next. A write sends the device address with R/W = 0, then a word address, then data bytes. Each data byte is stored where the counter points, and the counter then moves on. A read can start at the current counter value. It can also start at a new location, when the master first sends a word address (a write with no data) and then a repeated START with R/W = 1. While the master keeps acknowledging, the read continues byte after byte. The counter wraps from the top location back to location 0.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the SDA output enable is 0 and the address counter is 0. The memory contents are not cleared by reset, so a current-address read straight after reset returns the byte stored at location 0.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Both are recognised in any state. A START in the middle of a byte abandons that byte, and the next byte is taken as a device address.
- R3: The first byte after a START carries the device address in bits 7..1 (default 7'h50) and R/W in bit 0, where 1 means read. On a match the slave drives SDA low (ACK) during the ninth clock. On a mismatch it does not acknowledge and drives nothing until the next START, and the data bytes that follow are not stored.
- R4: In a write (R/W = 0), the second byte loads the address counter. Each further byte is acknowledged, stored at the counter, and the counter then increments.
- R5: A read that has no preceding word address returns the byte at the counter. The counter holds the last address read or written, plus one.
- R6: After a word address and a repeated START with R/W = 1, the slave acknowledges and returns the byte at that word address.
- R7: After each data byte sent, a master ACK (SDA low in the ninth clock) makes the slave send the byte at the next address.
- R8: The counter wraps from 255 to 0, for both writes and sequential reads, and the transfer continues without a break.
- R9: A master NACK (SDA high in the ninth clock) after a data byte ends the read. The slave releases SDA at once and returns to idle, and a later transaction is served normally.
- R10: Data bits are sent MSB first. The SDA output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain); 0 releases it |

## Verification
The bench writes a run of bytes across location 255 and then reads it back sequentially. A counter that saturates, or that rolls over at the wrong width, shows up as wrong bytes after 0xFF. It resets the block between a write and a current-address read. A counter that is not cleared by reset, or a memory that reset wipes, returns the wrong byte. It sends a device address that does not match, followed by a word address and data. A slave that acknowledges it, or that still stores the data, is caught on the ACK bits and by a later random read of that location. It also breaks off a byte halfway with a repeated START, ends reads with a NACK, and watches SDA for any change while SCL is high. A slave that ignores mid-byte STARTs, holds the bus after a NACK, or drives SDA during the high phase is reported.

// File: rtl/i2cm_pkg.sv
// Shared types for the I2C memory slave.
// Assumes one protocol engine per slave instance.
package i2cm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for START
        ST_RX,       // shifting in a byte from the master
        ST_ACKWAIT,  // byte complete, waiting for SCL low to answer
        ST_ACK,      // driving ACK through the ninth clock
        ST_TX,       // shifting a data byte out
        ST_RACK,     // sampling the master's ACK/NACK
        ST_IGNORE    // address mismatch, silent until START
    } st_t;

    typedef enum logic [1:0] {
        K_DEV,       // device address byte
        K_WADDR,     // word address byte
        K_WDATA      // data byte to store
    } kind_t;
endpackage

// File: rtl/i2cm_sync.sv
// Two-line input conditioner: a STAGES-deep synchroniser per line, plus
// edge and bus-condition detection on the synchronised pair.
// Assumes both lines idle high; line 0 is SCL and line 1 is SDA.
module i2cm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift the raw line through the synchroniser flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    // Keep last cycle's synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_det = prev[1] & ~synced[1] & synced[0] & prev[0];
    assign stop_det  = ~prev[1] & synced[1] & synced[0] & prev[0];

    // R2
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));
endmodule

// File: rtl/i2cm_mem.sv
// Byte array behind the slave: one synchronous write port and one
// combinational read port. Contents are deliberately kept through reset.
// Assumes a single writer.
module i2cm_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];

    // Store one byte when the protocol engine asks for it.
    always_ff @(posedge clk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/i2cm_fsm.sv
// Protocol engine: byte reception, address match, acknowledge, data
// transmit and the persistent address counter.
// Assumes synchronised SCL/SDA with single-cycle edge strobes, DW = 8
// (7-bit device address plus R/W), and AW <= DW.
module i2cm_fsm
    import i2cm_pkg::*;
#(
    parameter int          AW       = 8,
    parameter int          DW       = 8,
    parameter logic [6:0]  DEV_ADDR = 7'h50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          sda_oe
);
    localparam int          CW   = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    st_t           state;
    kind_t         kind;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh;
    logic [AW-1:0] addr;
    logic          rw;

    // Data byte is written at the counter as its ACK is driven.
    assign mem_we    = (state == ST_ACKWAIT) && scl_fall && (kind == K_WDATA)
                       && !start_det && !stop_det;
    assign mem_addr  = addr;
    assign mem_wdata = sh;

    // Main protocol sequencer, bus conditions take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind   <= K_DEV;
            cnt    <= '0;
            sh     <= '0;
            addr   <= '0;
            rw     <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            state  <= ST_RX;
            kind   <= K_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        sh <= {sh[DW-2:0], sda_s};
                        if (cnt == LAST) state <= ST_ACKWAIT;
                        else             cnt   <= cnt + 1'b1;
                    end
                end
                ST_ACKWAIT: begin
                    if (scl_fall) begin
                        case (kind)
                            K_DEV: begin
                                if (sh[DW-1 -: 7] == DEV_ADDR) begin
                                    rw     <= sh[0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end else begin
                                    state  <= ST_IGNORE;
                                end
                            end
                            K_WADDR: begin
                                addr   <= sh[AW-1:0];
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                            end
                            default: begin
                                addr   <= addr + 1'b1;
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (kind == K_DEV && rw) begin
                            sh     <= mem_rdata;
                            sda_oe <= ~mem_rdata[DW-1];
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                            kind   <= (kind == K_DEV) ? K_WADDR : K_WDATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt == LAST) begin
                            sda_oe <= 1'b0;
                            addr   <= addr + 1'b1;
                            state  <= ST_RACK;
                        end else begin
                            sh     <= {sh[DW-2:0], 1'b0};
                            sda_oe <= ~sh[DW-2];
                            cnt    <= cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (sda_s) state <= ST_IDLE;
                    end else if (scl_fall) begin
                        cnt    <= '0;
                        sh     <= mem_rdata;
                        sda_oe <= ~mem_rdata[DW-1];
                        state  <= ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    // R10
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R3
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);

    // R9
    nack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && scl_rise && sda_s && !start_det && !stop_det)
        |=> (state == ST_IDLE && !sda_oe));

    // R2
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX && kind == K_DEV && cnt == '0 && !sda_oe));

    // R7
    addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr) |-> ($past(state) == ST_ACKWAIT || $past(state) == ST_TX));
endmodule

// File: rtl/i2c_mem_slave.sv
// Top of the I2C memory slave: input conditioner, protocol engine and
// byte array. SDA is open-drain: sda_oe_o = 1 pulls the line low.
// Assumes clk runs at least about 16 times faster than SCL.
module i2c_mem_slave #(
    parameter int         AW       = 8,
    parameter int         DW       = 8,
    parameter int         STAGES   = 2,
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    i2cm_sync #(.STAGES(STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2cm_fsm #(.AW(AW), .DW(DW), .DEV_ADDR(DEV_ADDR)) fsm_i (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sda_oe(sda_oe_o)
    );

    i2cm_mem #(.AW(AW), .DW(DW)) mem_i (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr(mem_addr), .rdata(mem_rdata)
    );
endmodule

// File: tb/i2c_mem_slave_tb.sv
// Bus-master bench with a scoreboard: read tasks push expected bytes into
// a queue, and a monitor pops and compares every byte taken off the bus.
module i2c_mem_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;
    localparam logic [6:0] DEV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_bus;
    logic dut_oe;

    assign sda_bus = !(m_low || dut_oe);

    i2c_mem_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe_o(dut_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int viol = 0;
    bit finished = 1'b0;
    logic [7:0] exp_mem [256];
    logic [7:0] exp_addr = 8'h00;
    logic [7:0] exp_q [$];
    logic [7:0] wbuf [4];
    logic [7:0] got;
    string cur_req = "R5";
    event got_ev;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compare every byte read off the bus.
    initial begin
        forever begin
            @(got_ev);
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL %s actual=%0h expected=none", cur_req, got);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (got !== e) begin
                    miscompares++;
                    $display("FAIL %s actual=%0h expected=%0h", cur_req, got, e);
                end
            end
        end
    end

    // R10: SDA output enable must hold while SCL stays high.
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl && prev_scl && (dut_oe !== prev_oe)) viol++;
        prev_scl <= scl;
        prev_oe  <= dut_oe;
    end

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wait_q();
        scl = 1'b1;   wait_q();
        m_low = 1'b1; wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wait_q();
        scl = 1'b1;   wait_q();
        m_low = 1'b0; wait_q();
    endtask

    task automatic send_bit(input logic b);
        m_low = !b; wait_q();
        scl = 1'b1; wait_q(); wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; wait_q();
        scl = 1'b1;   wait_q();
        b = sda_bus;  wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic read_byte(input bit give_ack);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            v[i] = b;
        end
        got = v;
        ->got_ev;
        send_bit(!give_ack);
    endtask

    // Read n bytes from the expected counter, NACK the last, then STOP.
    task automatic read_run(input int n, input string req);
        cur_req = req;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(exp_mem[exp_addr]);
            exp_addr = exp_addr + 8'd1;
            read_byte(i != n - 1);
        end
        check({"R9 release after NACK (", req, ")"}, {31'd0, dut_oe}, 32'd0);
        bus_stop();
    endtask

    task automatic mem_write(input logic [7:0] a, input int n);
        logic ack;
        bus_start();
        send_byte({DEV, 1'b0}, ack); check("R3 ack on write address", {31'd0, ack}, 32'd1);
        send_byte(a, ack);           check("R4 ack on word address", {31'd0, ack}, 32'd1);
        exp_addr = a;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            check("R4 ack on data byte", {31'd0, ack}, 32'd1);
            exp_mem[exp_addr] = wbuf[i];
            exp_addr = exp_addr + 8'd1;
        end
        bus_stop();
    endtask

    task automatic random_read(input logic [7:0] a, input int n, input string req);
        logic ack;
        bus_start();
        send_byte({DEV, 1'b0}, ack); check({req, " dummy write ack"}, {31'd0, ack}, 32'd1);
        send_byte(a, ack);           check({req, " word address ack"}, {31'd0, ack}, 32'd1);
        exp_addr = a;
        bus_start();
        send_byte({DEV, 1'b1}, ack); check({req, " read address ack"}, {31'd0, ack}, 32'd1);
        read_run(n, req);
    endtask

    task automatic current_read(input int n, input string req);
        logic ack;
        bus_start();
        send_byte({DEV, 1'b1}, ack); check({req, " read address ack"}, {31'd0, ack}, 32'd1);
        read_run(n, req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        exp_addr = 8'h00;
        repeat (5) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    // Test sequence.
    initial begin
        logic ack;
        do_reset();
        check("R1 output enable after reset", {31'd0, dut_oe}, 32'd0);

        // R1: counter clears on reset, memory keeps its contents.
        wbuf[0] = 8'h5A;
        mem_write(8'h00, 1);
        do_reset();
        check("R1 output enable after second reset", {31'd0, dut_oe}, 32'd0);
        current_read(1, "R1");

        // R4 write, then R6 random read and R7 sequential continuation.
        wbuf[0] = 8'hA0; wbuf[1] = 8'h1E; wbuf[2] = 8'hC3; wbuf[3] = 8'h81;
        mem_write(8'h10, 4);
        random_read(8'h11, 2, "R6");
        current_read(1, "R5");
        random_read(8'h10, 4, "R7");

        // R3: mismatched address is ignored, and its data is not stored.
        bus_start();
        send_byte({7'h51, 1'b0}, ack); check("R3 no ack on other address", {31'd0, ack}, 32'd0);
        send_byte(8'h10, ack);         check("R3 no ack while ignoring", {31'd0, ack}, 32'd0);
        send_byte(8'hEE, ack);         check("R3 no ack on ignored data", {31'd0, ack}, 32'd0);
        bus_stop();
        random_read(8'h10, 1, "R3");

        // R8: write and read back across the top of the memory.
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        mem_write(8'hFE, 4);
        random_read(8'hFE, 4, "R8");

        // R2: START in the middle of a byte restarts address reception.
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_byte({DEV, 1'b1}, ack); check("R2 ack after mid-byte START", {31'd0, ack}, 32'd1);
        read_run(1, "R2");

        // R9: slave is usable again after the NACK-terminated reads.
        random_read(8'h12, 1, "R9");

        check("R10 SDA stable while SCL high", viol, 32'd0);
        check("R10 scoreboard drained", exp_q.size(), 32'd0);
        summary();
        $finish;
    end
endmodule